// File: doc/BRIEF.md
# Array Stride Prefetch Table

This block watches the stream of array loads and stores coming out of an execution core and issues data prefetch requests for the elements that a strided loop will touch next. Every access arrives with the array's base address, the element address, the array length in elements and the element size. The table keys each entry on the array base. It therefore learns one stride per array, however many instructions walk that array.

An entry first learns the byte distance between two consecutive accesses to its array. It must then see that same nonzero distance repeat a configurable number of times before it issues any prefetch. Once the stride is trusted, every access yields a candidate address a configurable number of strides ahead, rounded down to a cache line. The array length bounds that candidate. A candidate past the last element, or before the first for a descending walk, is dropped. When the wrap mode input is set, the candidate is replaced by the line where the next pass of the loop will start. Requests leave on a single valid/ready port. Repeats of the line sent just before are filtered out.

Top module: `arr_stride_pf`

## Requirements
- R1: After reset, `pf_valid` is low and the table holds no entries.
- R2: An array access whose base matches no entry claims an entry and produces no prefetch request.
- R3: With the default threshold of 2 and depth of 2, the fourth and later accesses of an array walked with a constant nonzero stride produce requests. The first three accesses do not. The stride is loaded by the second access and confirmed by two further matches.
- R4: An access whose observed stride differs from the stored stride replaces it and clears the confirmation. No request follows until two further matching accesses have been seen.
- R5: A confirmed access requests address + DEPTH × stride with the low four address bits cleared (16-byte lines). The request appears on `pf_valid`/`pf_addr` one clock after the access.
- R6: With `wrap_en` low, a candidate at or beyond base + (length << esz) for an ascending stride, or below base for a descending stride, produces no request.
- R7: With `wrap_en` high, such an out-of-range candidate is replaced by the line of the base address for an ascending stride. For a descending stride it is replaced by the line of the last element.
- R8: A candidate whose line equals the line of the previously accepted request produces no request.
- R9: Accesses with `acc_is_array` low neither produce requests nor alter any entry.
- R10: When all 8 entries are in use, a new base displaces the entries in round-robin order. Eight further new bases therefore evict a learned array, and that array must learn again.
- R11: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` hold. A request produced during that time is discarded.
- R12: A zero stride never confirms an entry, however often it repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_is_array | input | 1 | High for array element accesses, low for field accesses |
| acc_base | input | ADDR_W | Base address of the accessed array |
| acc_addr | input | ADDR_W | Byte address of the accessed element |
| acc_len | input | LEN_W | Array length in elements |
| acc_esz | input | 2 | log2 of the element size in bytes |
| wrap_en | input | 1 | Replace out-of-range candidates by the start of the next pass |
| pf_ready | input | 1 | Consumer accepts the current request |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |

## Verification
The hardest state to reach is a confirmed entry whose look-ahead target crosses the array end while the output is back-pressured. In that state the wrap decision, the line filter and the drop-on-stall rule all act in the same cycle. Directed walks drive short arrays to their tails in both directions, with the wrap input set and clear. A random phase follows that interleaves six arrays of random size, element width and stride with field accesses, idle cycles and random `pf_ready`. The walks restart at the head, so tail crossings recur under stall. Every cycle is compared against a bench model of the table.

// File: rtl/apf_pkg.sv
// Package: shared encodings for the array stride prefetch table.
// Assumes nothing beyond standard SystemVerilog.
package apf_pkg;

    // Outcome of the look-ahead target computation
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,   // candidate dropped (out of range, no wrap)
        TGT_AHEAD = 2'd1,   // candidate lies inside the array
        TGT_WRAP  = 2'd2    // candidate replaced by start of next pass
    } tgt_kind_e;

    // Clear the offset-in-line bits of an address
    function automatic logic [63:0] line_of(input logic [63:0] a, input int unsigned line_bytes);
        return a & ~(64'(line_bytes) - 64'd1);
    endfunction

endpackage

// File: rtl/apf_lookup.sv
// apf_lookup: compares the presented array base against every valid tag.
// Assumes the table never holds two valid entries with the same tag.
module apf_lookup #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              tag_vld [ENTRIES],
    input  logic [ADDR_W-1:0] tag     [ENTRIES],
    input  logic [ADDR_W-1:0] key,
    output logic [ENTRIES-1:0] hit_vec,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);

    // One comparator per entry
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = tag_vld[e] && (tag[e] == key);
    end

    assign hit = |hit_vec;

    // Encode the matching entry number
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/apf_target.sv
// apf_target: forms the look-ahead address DEPTH strides past the current
// access, bounds it by the array extent and optionally wraps it to the
// start of the next pass. Output is line aligned.
// Assumes stride is nonzero when the result is used.
module apf_target
    import apf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DEPTH      = 2,
    parameter int LINE_BYTES = 16,
    localparam int EW        = ADDR_W + $clog2(DEPTH + 1) + LEN_W + 4
) (
    input  logic                     wrap_en,
    input  logic [ADDR_W-1:0]        base,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LEN_W-1:0]         len,
    input  logic [1:0]               esz,
    input  logic signed [ADDR_W-1:0] stride,
    output tgt_kind_e                kind,
    output logic [ADDR_W-1:0]        line_addr
);

    logic signed [EW-1:0] base_x, addr_x, str_x, depth_x;
    logic signed [EW-1:0] ahead, end_x, last_x, tgt;
    logic                 up, in_rng;

    // Widen operands so no sum or product can overflow
    always_comb begin
        base_x  = signed'({{(EW-ADDR_W){1'b0}}, base});
        addr_x  = signed'({{(EW-ADDR_W){1'b0}}, addr});
        str_x   = signed'({{(EW-ADDR_W){stride[ADDR_W-1]}}, stride});
        depth_x = signed'(EW'(DEPTH));
        ahead   = addr_x + depth_x * str_x;
        end_x   = base_x + signed'(EW'(len) << esz);
        last_x  = end_x - signed'(EW'(1) << esz);
    end

    // Range test against the direction of travel
    always_comb begin
        up     = !stride[ADDR_W-1];
        in_rng = up ? (ahead < end_x) : (ahead >= base_x);
    end

    // Pick the surviving target and classify it
    always_comb begin
        if (in_rng) begin
            kind = TGT_AHEAD;
            tgt  = ahead;
        end else if (wrap_en) begin
            kind = TGT_WRAP;
            tgt  = up ? base_x : last_x;
        end else begin
            kind = TGT_NONE;
            tgt  = ahead;
        end
        line_addr = tgt[ADDR_W-1:0] & ~ADDR_W'(LINE_BYTES - 1);
    end

endmodule

// File: rtl/apf_issue.sv
// apf_issue: single-register request port. Filters a candidate that repeats
// the line of the last accepted request and discards candidates that arrive
// while the current request is stalled.
// Assumes cand_line is already line aligned.
module apf_issue #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_line,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    logic              last_vld;
    logic [ADDR_W-1:0] last_line;
    logic              fresh;
    logic              slot_free;

    // Candidate survives the repeat filter
    assign fresh     = cand_valid && !(last_vld && (last_line == cand_line));
    // Output register may take a new value
    assign slot_free = !pf_valid || pf_ready;

    // Load, hold or clear the request register and remember the last line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid  <= 1'b0;
            pf_addr   <= '0;
            last_vld  <= 1'b0;
            last_line <= '0;
        end else if (slot_free) begin
            pf_valid <= fresh;
            if (fresh) begin
                pf_addr   <= cand_line;
                last_vld  <= 1'b1;
                last_line <= cand_line;
            end
        end
    end

endmodule

// File: rtl/arr_stride_pf.sv
// arr_stride_pf: base-tagged stride table for array prefetching.
// Each entry learns the byte stride of one array, confirms it over HIST
// repeats and then requests the line DEPTH strides ahead, bounded by the
// array length, with optional wrap to the next pass start.
// Assumes one access per cycle at most and that acc_len/acc_esz describe
// the array named by acc_base.
module arr_stride_pf
    import apf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int ENTRIES    = 8,
    parameter int HIST       = 2,
    parameter int DEPTH      = 2,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_array,
    input  logic [ADDR_W-1:0] acc_base,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LEN_W-1:0]  acc_len,
    input  logic [1:0]        acc_esz,
    input  logic              wrap_en,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(HIST + 1);

    // Table storage
    logic                     ent_vld    [ENTRIES];
    logic [ADDR_W-1:0]        ent_tag    [ENTRIES];
    logic [ADDR_W-1:0]        ent_last   [ENTRIES];
    logic signed [ADDR_W-1:0] ent_stride [ENTRIES];
    logic [CNT_W-1:0]         ent_cnt    [ENTRIES];
    logic [IDX_W-1:0]         rr_ptr;

    logic [ENTRIES-1:0]       hit_vec;
    logic                     hit;
    logic [IDX_W-1:0]         hit_idx;

    logic                     do_upd;
    logic signed [ADDR_W-1:0] obs_stride, cur_stride;
    logic                     matched, confirm;
    logic [CNT_W-1:0]         cnt_next;
    tgt_kind_e                kind;
    logic [ADDR_W-1:0]        cand_line;
    logic                     cand_valid;

    // Only array element accesses touch the table
    assign do_upd = acc_valid && acc_is_array;

    apf_lookup #(
        .ADDR_W (ADDR_W),
        .ENTRIES(ENTRIES)
    ) u_lookup (
        .tag_vld(ent_vld),
        .tag    (ent_tag),
        .key    (acc_base),
        .hit_vec(hit_vec),
        .hit    (hit),
        .hit_idx(hit_idx)
    );

    // Compare the observed stride with the stored one and advance confirmation
    always_comb begin
        cur_stride = ent_stride[hit_idx];
        obs_stride = signed'(acc_addr - ent_last[hit_idx]);
        matched    = (obs_stride == cur_stride) && (cur_stride != '0);
        if (!matched)
            cnt_next = '0;
        else if (ent_cnt[hit_idx] == CNT_W'(HIST))
            cnt_next = ent_cnt[hit_idx];
        else
            cnt_next = ent_cnt[hit_idx] + 1'b1;
        confirm = matched && (cnt_next == CNT_W'(HIST));
    end

    apf_target #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .DEPTH     (DEPTH),
        .LINE_BYTES(LINE_BYTES)
    ) u_target (
        .wrap_en  (wrap_en),
        .base     (acc_base),
        .addr     (acc_addr),
        .len      (acc_len),
        .esz      (acc_esz),
        .stride   (cur_stride),
        .kind     (kind),
        .line_addr(cand_line)
    );

    // A confirmed hit with a surviving target offers a request
    assign cand_valid = do_upd && hit && confirm && (kind != TGT_NONE);

    apf_issue #(
        .ADDR_W(ADDR_W)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_valid(cand_valid),
        .cand_line (cand_line),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    // Per-entry state: allocate on miss at the round-robin slot, train on hit
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic sel_hit, sel_alloc;
        assign sel_hit   = do_upd && hit && (hit_idx == IDX_W'(e));
        assign sel_alloc = do_upd && !hit && (rr_ptr == IDX_W'(e));

        // Valid bit carries the reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_vld[e] <= 1'b0;
            else if (sel_alloc)
                ent_vld[e] <= 1'b1;
        end

        // Tag, last address, stride and count need no reset
        always_ff @(posedge clk) begin
            if (sel_alloc) begin
                ent_tag[e]    <= acc_base;
                ent_last[e]   <= acc_addr;
                ent_stride[e] <= '0;
                ent_cnt[e]    <= '0;
            end else if (sel_hit) begin
                ent_last[e] <= acc_addr;
                ent_cnt[e]  <= cnt_next;
                if (!matched) ent_stride[e] <= obs_stride;
            end
        end
    end

    // Round-robin victim pointer advances on every allocation
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (do_upd && !hit)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end

endmodule

// File: rtl/apf_checker.sv
// apf_checker: protocol and structural properties of arr_stride_pf,
// attached to every instance with bind.
module apf_checker #(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 8,
    parameter int LINE_BYTES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_is_array,
    input logic               pf_valid,
    input logic               pf_ready,
    input logic [ADDR_W-1:0]  pf_addr,
    input logic [ENTRIES-1:0] hit_vec
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pf_valid);                                        // R1

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));                                                 // R2

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_array && hit_vec == '0 && !(pf_valid && !pf_ready))
        |=> !pf_valid);                                                     // R2

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ((pf_addr & ADDR_W'(LINE_BYTES - 1)) == '0));          // R5

    AST_FIELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_array && !(pf_valid && !pf_ready))
        |=> !pf_valid);                                                     // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));        // R11

endmodule

bind arr_stride_pf apf_checker #(
    .ADDR_W    (ADDR_W),
    .ENTRIES   (ENTRIES),
    .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_is_array(acc_is_array),
    .pf_valid    (pf_valid),
    .pf_ready    (pf_ready),
    .pf_addr     (pf_addr),
    .hit_vec     (hit_vec)
);

// File: tb/arr_stride_pf_test.sv
`timescale 1ns/1ps
module arr_stride_pf_test;

    localparam int    AW = 32;
    localparam int    LW = 16;
    localparam int    NE = 8;
    localparam int    H  = 2;
    localparam int    D  = 2;
    localparam int    LB = 16;
    localparam real   CLK_NS = 5.0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_is_array = 1'b0;
    logic [AW-1:0] acc_base = '0, acc_addr = '0;
    logic [LW-1:0] acc_len = '0;
    logic [1:0]    acc_esz = '0;
    logic          wrap_en = 1'b0, pf_ready = 1'b1;
    logic          pf_valid;
    logic [AW-1:0] pf_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    arr_stride_pf #(.ADDR_W(AW), .LEN_W(LW), .ENTRIES(NE), .HIST(H),
                    .DEPTH(D), .LINE_BYTES(LB)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_array(acc_is_array),
        .acc_base(acc_base), .acc_addr(acc_addr), .acc_len(acc_len), .acc_esz(acc_esz),
        .wrap_en(wrap_en), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr));

    // ---------------- reference model (built from the requirements) --------
    bit     m_vld [NE];
    longint m_tag [NE], m_last [NE], m_str [NE];
    int     m_cnt [NE];
    int     m_rr = 0;
    bit     m_lvld = 0;
    longint m_lline = 0;
    bit     e_valid = 0;
    longint e_addr = 0;

    function automatic longint to_line(longint a);
        return a & ~longint'(LB - 1);
    endfunction

    // Advance the model by one clock with the inputs currently driven
    function automatic void model_step();
        bit     req = 0;
        longint ln = 0;
        if (acc_valid && acc_is_array) begin
            int hi = -1;
            for (int i = 0; i < NE; i++)
                if (m_vld[i] && m_tag[i] == longint'(acc_base)) hi = i;
            if (hi < 0) begin
                m_vld[m_rr] = 1; m_tag[m_rr] = acc_base; m_last[m_rr] = acc_addr;
                m_str[m_rr] = 0; m_cnt[m_rr] = 0;
                m_rr = (m_rr + 1) % NE;
            end else begin
                longint ns = longint'(acc_addr) - m_last[hi];
                bit     mt = (ns == m_str[hi]) && (m_str[hi] != 0);
                m_cnt[hi] = mt ? ((m_cnt[hi] < H) ? m_cnt[hi] + 1 : H) : 0;
                if (!mt) m_str[hi] = ns;
                m_last[hi] = acc_addr;
                if (mt && m_cnt[hi] == H) begin
                    longint b  = acc_base;
                    longint en = b + (longint'(acc_len) << acc_esz);
                    longint t  = longint'(acc_addr) + D * m_str[hi];
                    bit     ok = (m_str[hi] > 0) ? (t < en) : (t >= b);
                    if (ok) begin req = 1; ln = to_line(t); end
                    else if (wrap_en) begin
                        req = 1;
                        ln  = to_line((m_str[hi] > 0) ? b : en - (longint'(1) << acc_esz));
                    end
                    if (req && m_lvld && ln == m_lline) req = 0;
                end
            end
        end
        if (!e_valid || pf_ready) begin
            e_valid = req;
            if (req) begin e_addr = ln; m_lvld = 1; m_lline = ln; end
        end
    endfunction

    task automatic compare(string req);
        checks++;
        if (pf_valid !== e_valid || (e_valid && pf_addr !== e_addr[AW-1:0])) begin
            errors++;
            $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
                     req, pf_valid, pf_addr, e_valid, e_addr[AW-1:0]);
        end
    endtask

    // One clock: model, edge, sample away from the edge, return to negedge
    task automatic step(string req);
        model_step();
        @(posedge clk); #1;
        compare(req);
        @(negedge clk);
    endtask

    task automatic acc(string req, bit arr, longint base, longint addr, int len, int esz);
        acc_valid = 1; acc_is_array = arr; acc_base = base[AW-1:0];
        acc_addr = addr[AW-1:0]; acc_len = len[LW-1:0]; acc_esz = esz[1:0];
        step(req);
        acc_valid = 0;
    endtask

    task automatic idle(string req);
        acc_valid = 0;
        step(req);
    endtask

    // Walk n elements of an array starting at element i0 with element stride se
    task automatic walk(string req, longint base, int len, int esz, int i0, int se, int n);
        for (int k = 0; k < n; k++)
            acc(req, 1, base, base + (longint'(i0 + k * se) << esz), len, esz);
    endtask

    // ---------------- random-phase state ----------------------------------
    longint rb [6];
    int     rl [6], re [6], rs [6], ri [6];

    initial begin
        void'($urandom(32'h5EED_0A11));
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: idle output under and right after reset
        #0; checks++;
        if (pf_valid !== 1'b0) begin
            errors++; $display("FAIL R1: pf_valid=%0b expected 0", pf_valid);
        end
        rst_n = 1;
        idle("R1");

        // R2 + R3 + R5: ascending word walk, request from the fourth access on
        wrap_en = 0;
        walk("R3", 64'h1000, 64, 2, 0, 1, 3);
        walk("R5", 64'h1000, 64, 2, 3, 1, 1);       // 0x100C -> line 0x1010
        walk("R8", 64'h1000, 64, 2, 4, 1, 1);       // same line again: filtered
        walk("R5", 64'h1000, 64, 2, 5, 1, 6);
        idle("R5");

        // R4: stride change clears confirmation
        walk("R4", 64'h1000, 64, 2, 11, 3, 3);
        walk("R4", 64'h1000, 64, 2, 20, 3, 2);

        // R12: zero stride never confirms
        walk("R12", 64'h5000, 16, 3, 4, 0, 6);

        // R6: tail suppression without wrap (len 8, words)
        wrap_en = 0;
        walk("R6", 64'h2000, 8, 2, 0, 1, 8);
        idle("R6");
        // R7: wrap to head, ascending
        wrap_en = 1;
        walk("R7", 64'h2400, 8, 2, 0, 1, 8);
        // R7: wrap to last element, descending
        walk("R7", 64'h2800, 8, 2, 7, -1, 8);
        idle("R7");

        // R9: field accesses interleaved in a confirmed walk change nothing
        walk("R9", 64'h3000, 128, 1, 0, 2, 5);
        acc("R9", 0, 64'h3000, 64'h3FF0, 128, 1);
        acc("R9", 0, 64'h3000, 64'h3000, 128, 1);
        walk("R9", 64'h3000, 128, 1, 10, 2, 2);

        // R11: stall holds the request, a new one during the stall is dropped
        walk("R11", 64'h3000, 128, 1, 12, 2, 2);
        pf_ready = 0;
        walk("R11", 64'h3000, 128, 1, 16, 2, 8);
        pf_ready = 1;
        idle("R11");
        idle("R11");

        // R10: eight new bases evict a learned array, which then relearns
        walk("R10", 64'h6000, 64, 2, 0, 1, 5);
        for (int k = 0; k < NE; k++)
            acc("R10", 1, 64'h7000 + k * 64'h100, 64'h7000 + k * 64'h100, 16, 2);
        walk("R10", 64'h6000, 64, 2, 5, 1, 5);

        // Random phase: six arrays, field accesses, idles, random ready
        for (int j = 0; j < 6; j++) begin
            rb[j] = 64'h10_0000 * (j + 1) + 16 * ($urandom % 256);
            rl[j] = 16 + $urandom % 64;
            re[j] = $urandom % 3;
            case ($urandom % 5)
                0: rs[j] = 1;  1: rs[j] = 2;  2: rs[j] = 3;
                3: rs[j] = -1; default: rs[j] = -2;
            endcase
            ri[j] = (rs[j] > 0) ? 0 : rl[j] - 1;
        end
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom % 100;
            int j = $urandom % 6;
            pf_ready = (($urandom % 10) != 0);
            if (n % 250 == 0) wrap_en = ~wrap_en;
            if (r < 8) idle("R11");
            else if (r < 16) acc("R9", 0, rb[j], rb[j] + ($urandom % 512), rl[j], re[j]);
            else begin
                acc("R5", 1, rb[j], rb[j] + (longint'(ri[j]) << re[j]), rl[j], re[j]);
                ri[j] += rs[j];
                if (ri[j] >= rl[j]) ri[j] = 0;
                if (ri[j] < 0) ri[j] = rl[j] - 1;
                if (r == 99) rs[j] = (rs[j] > 0) ? -rs[j] : 1 + $urandom % 3;
            end
        end
        pf_ready = 1;
        idle("R11");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule